// File: doc/BRIEF.md
# Configuration Image Fetch with Checksum Status and Signature Gate

After a start pulse, this block reads a fixed-size configuration image from a word-wide memory port. The image has 64 words of 16 bits at addresses 0 to 63, and the last word holds the checksum. Only one read is outstanding at a time. The block sends each word it receives out on a pass-through word stream, so a downstream register file can stage it. It also adds every word, the checksum word included, into a wrapping 16-bit sum.

At the end of the fetch, the block raises a one-cycle done pulse. With that pulse it reports two separate results:

- A status flag that tells whether the sum equals a parameterized expected constant. This flag is informational and intended for software.
- A configuration-apply strobe. It depends only on a 2-bit signature field taken from the initialization control word.

The checksum result never decides whether configuration is applied. A downstream consumer commits its staged words only when it sees the apply strobe.

Top module: `cfg_image_loader`

## Requirements
- R1: While reset is asserted and after its release, `rd_req`, `word_valid`, `busy`, `done`, `sum_ok` and `cfg_apply` are all 0.
- R2: A `start` pulse while idle begins a fetch. The fetch issues one-cycle `rd_req` pulses at addresses 0, 1, … 63 in ascending order. A new request is issued only after `rd_valid` has answered the previous one.
- R3: Each word accepted on `rd_valid` appears, unchanged and in the same cycle, on `word_data`, with `word_valid` high and `word_addr` equal to its address.
- R4: `sum_ok` is 1 exactly when the modulo-2^16 sum of all 64 received words equals `EXP_SUM`. The result is valid from the done cycle and is held until the next accepted start. It is 0 while a fetch is in progress.
- R5: The signature is bits [15:14] of the word at address `SIG_ADDR` (default 10). `cfg_apply` pulses together with `done` exactly when the signature equals 2'b01. This holds whatever the value of `sum_ok`.
- R6: `done` is a one-cycle pulse in the cycle after the word at address 63 is accepted. `busy` is high from the cycle after an accepted start through the done cycle, and is low afterwards.
- R7: `start` while `busy` is high has no effect. `rd_valid` while no request is outstanding has no effect: it produces no `word_valid` and does not start a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fetch when idle |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | 6 | Word address of the request |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 16 | Read data word |
| word_valid | output | 1 | Pass-through word strobe |
| word_addr | output | 6 | Address of the pass-through word |
| word_data | output | 16 | Pass-through word |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | Fetch complete pulse |
| sum_ok | output | 1 | Image sum equals the expected constant |
| cfg_apply | output | 1 | Signature valid; commit staged configuration |

## Verification
The assertions assume that the memory side answers every request with exactly one `rd_valid`. Under that assumption, the running word index in the checker always matches `word_addr`. The stimulus keeps within this assumption: a responder in the bench replies once, one cycle after each request. Deliberate out-of-protocol `rd_valid` pulses are injected only while the block is idle, where no request can be pending. The stimulus exercises the interesting combinations of the two results: a good image, a corrupted image with a valid signature, and bad signatures with a correct sum.

// File: rtl/cfg_image_loader.sv
module cfg_image_loader #(
  parameter int DW       = 16,
  parameter int WORDS    = 64,
  parameter int SIG_ADDR = 10,
  parameter int SIG_HI   = 15,
  parameter logic [15:0] EXP_SUM = 16'hBABA,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          word_valid,
  output logic [AW-1:0] word_addr,
  output logic [DW-1:0] word_data,
  output logic          busy,
  output logic          done,
  output logic          sum_ok,
  output logic          cfg_apply
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);
  localparam logic [AW-1:0] SIGA = AW'(SIG_ADDR);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_FIN} state_t;

  state_t        state;
  logic [AW-1:0] addr;
  logic [DW-1:0] sum;
  logic [1:0]    sig;
  logic          take;

  assign take       = (state == S_WAIT) && rd_valid;
  assign rd_req     = (state == S_REQ);
  assign rd_addr    = addr;
  assign word_valid = take;
  assign word_addr  = addr;
  assign word_data  = rd_data;
  assign busy       = (state != S_IDLE);
  assign done       = (state == S_FIN);
  assign cfg_apply  = done && (sig == 2'b01);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      addr   <= '0;
      sum    <= '0;
      sig    <= '0;
      sum_ok <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state  <= S_REQ;
          addr   <= '0;
          sum    <= '0;
          sig    <= '0;
          sum_ok <= 1'b0;
        end
        S_REQ: state <= S_WAIT;
        S_WAIT: if (rd_valid) begin
          sum <= sum + rd_data;
          if (addr == SIGA) sig <= rd_data[SIG_HI -: 2];
          if (addr == LAST) begin
            state  <= S_FIN;
            sum_ok <= ((sum + rd_data) == DW'(EXP_SUM));
          end else begin
            addr  <= addr + 1'b1;
            state <= S_REQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_image_loader_chk.sv
module cfg_image_loader_chk #(
  parameter int WORDS = 64,
  localparam int AW = $clog2(WORDS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          rd_req,
  input logic          rd_valid,
  input logic          word_valid,
  input logic [AW-1:0] word_addr,
  input logic          busy,
  input logic          done,
  input logic          sum_ok,
  input logic          cfg_apply
);
  logic          outst;
  logic [AW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst <= 1'b0;
      cnt   <= '0;
    end else begin
      if (start && !busy) cnt <= '0;
      else if (word_valid) cnt <= cnt + 1'b1;
      if (rd_req) outst <= 1'b1;
      else if (rd_valid) outst <= 1'b0;
    end
  end

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !outst);
  assert_word_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (word_addr == cnt) && busy);
  assert_sum_hidden_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |-> !sum_ok);
  assert_sum_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(sum_ok));
  assert_apply_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_apply |-> done);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !word_valid && !rd_req);
endmodule

bind cfg_image_loader cfg_image_loader_chk #(.WORDS(WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req),
  .rd_valid(rd_valid), .word_valid(word_valid), .word_addr(word_addr),
  .busy(busy), .done(done), .sum_ok(sum_ok), .cfg_apply(cfg_apply)
);

// File: tb/cfg_image_loader_bench.sv
module cfg_image_loader_bench;
  localparam logic [15:0] EXP = 16'hBABA;
  localparam int SIGA = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rd_req, rd_valid, word_valid, busy, done, sum_ok, cfg_apply;
  logic [5:0] rd_addr, word_addr;
  logic [15:0] rd_data, word_data;

  always #4 clk = ~clk;

  cfg_image_loader #(.EXP_SUM(EXP), .SIG_ADDR(SIGA)) u_cfg_image_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .word_valid(word_valid),
    .word_addr(word_addr), .word_data(word_data), .busy(busy), .done(done),
    .sum_ok(sum_ok), .cfg_apply(cfg_apply)
  );

  logic [15:0] img [64];
  logic        pend = 1'b0;
  logic [5:0]  paddr = '0;
  logic        spur = 1'b0;
  int checks = 0, fails = 0;
  int nwords = 0, nbad = 0, nreq = 0;

  always @(posedge clk) begin
    rd_valid <= 1'b0;
    pend     <= 1'b0;
    if (rd_req) begin pend <= 1'b1; paddr <= rd_addr; end
    if (pend) begin rd_valid <= 1'b1; rd_data <= img[paddr]; end
    else if (spur) begin rd_valid <= 1'b1; rd_data <= 16'hFFFF; end
  end

  always @(negedge clk) begin
    if (rd_req) nreq++;
    if (word_valid) begin
      if (word_addr != 6'(nwords) || word_data != img[word_addr]) nbad++;
      nwords++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build(input logic [15:0] seed, input logic [1:0] sig, input bit corrupt);
    logic [15:0] s = '0;
    for (int i = 0; i < 63; i++) begin
      img[i] = seed ^ 16'(i * 16'h0451);
      if (i == SIGA) img[i] = {sig, img[i][13:0]};
      s = s + img[i];
    end
    img[63] = EXP - s;
    if (corrupt) img[5] = img[5] ^ 16'h0100;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  // {seed, sig, corrupt, exp_sum_ok, exp_apply}
  localparam logic [20:0] VEC [5] = '{
    {16'h1234, 2'b01, 1'b0, 1'b1, 1'b1},
    {16'h1234, 2'b01, 1'b1, 1'b0, 1'b1},
    {16'hA5C3, 2'b10, 1'b0, 1'b1, 1'b0},
    {16'h0F0F, 2'b11, 1'b0, 1'b1, 1'b0},
    {16'h7E01, 2'b00, 1'b1, 1'b0, 1'b0}
  };

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    build(16'h0, 2'b01, 1'b0);
    repeat (3) @(negedge clk);
    check({rd_req, word_valid, busy, done, sum_ok, cfg_apply} == 6'b0, "R1 in reset",
          {rd_req, word_valid, busy, done, sum_ok, cfg_apply}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({rd_req, word_valid, busy, done, sum_ok, cfg_apply} == 6'b0, "R1 after reset",
          {rd_req, word_valid, busy, done, sum_ok, cfg_apply}, 0);

    foreach (VEC[v]) begin
      build(VEC[v][20:5], VEC[v][4:3], VEC[v][2]);
      nwords = 0; nbad = 0; nreq = 0;
      pulse_start();
      check(busy == 1'b1, "R6 busy after start", busy, 1);
      wait_done(ok);
      check(ok, "R6 done reached", ok, 1);
      check(sum_ok == VEC[v][1], "R4 sum flag", sum_ok, VEC[v][1]);
      check(cfg_apply == VEC[v][0], "R5 apply from signature", cfg_apply, VEC[v][0]);
      check(nwords == 64 && nbad == 0 && nreq == 64, "R2 R3 word stream",
            nwords * 1000 + nbad, 64000);
      @(negedge clk);
      check({done, busy, cfg_apply} == 3'b0, "R6 done one cycle", {done, busy, cfg_apply}, 0);
      repeat (3) @(negedge clk);
      check(sum_ok == VEC[v][1], "R4 sum flag held", sum_ok, VEC[v][1]);
    end

    // R7: start while busy is ignored
    build(16'h5555, 2'b01, 1'b0);
    nwords = 0; nbad = 0; nreq = 0;
    pulse_start();
    repeat (20) @(negedge clk);
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_done(ok);
    check(ok && nwords == 64 && nbad == 0, "R7 start while busy", nwords * 1000 + nbad, 64000);
    check(sum_ok && cfg_apply, "R7 result unaffected", {sum_ok, cfg_apply}, 3);

    // R7: stray rd_valid while idle
    repeat (2) @(negedge clk);
    nwords = 0;
    spur = 1'b1;
    repeat (4) @(negedge clk);
    spur = 1'b0;
    repeat (2) @(negedge clk);
    check(nwords == 0 && !busy && sum_ok, "R7 stray valid ignored",
          {nwords[3:0], busy, sum_ok}, 1);

    // R4: sum flag cleared at next start
    build(16'h3333, 2'b01, 1'b1);
    pulse_start();
    check(sum_ok == 1'b0, "R4 cleared on start", sum_ok, 0);
    wait_done(ok);
    check(ok && !sum_ok && cfg_apply, "R5 apply despite bad sum", {sum_ok, cfg_apply}, 1);

    // R1: reset mid-fetch
    pulse_start();
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({rd_req, busy, done, sum_ok, cfg_apply} == 5'b0, "R1 reset mid-fetch",
          {rd_req, busy, done, sum_ok, cfg_apply}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule